// File: doc/BRIEF.md
# Fully Associative Cache with Victim Buffer

This block is a small cache in which any line of memory may sit in any of its main slots. Every slot holds its own tag comparator, so a lookup is a single parallel match across the array. A short buffer of recently displaced lines is searched in the same cycle as the main array. A CPU access therefore either completes in the cycle it is presented or raises `stall`. Recency among the main slots is tracked exactly, and the least recently used slot is the one displaced.

A line is two words wide. When neither the main array nor the buffer holds the requested line, the block asks memory for that line and receives both words together as one burst. It then installs them and releases the stall. The CPU holds its request steady while `stall` is high and sees the access complete once `stall` falls. A line pushed out of the main array moves into the victim buffer. A hit in the buffer trades that entry with the main array's displacement candidate in a single cycle. Each line carries a dirty flag that moves with it. Written-back data to memory is not produced.

Top module: `fa_victim_cache`

## Requirements
- R1: After reset `stall` and `memReq` are low and every main slot and buffer entry is invalid, so the first access to any line misses.
- R2: A read that matches a main slot returns the addressed word (offset bit `reqAddr[0]`) in the same cycle with `stall` low.
- R3: A write that hits changes only the addressed word of the line, and a later read of that word returns the written value.
- R4: An access that matches neither the main array nor the buffer raises `stall` in that cycle. From the next cycle `memReq` is high with `memAddr` equal to `reqAddr[ADDR_W-1:1]`, held unchanged until `memValid`.
- R5: On `memValid` the low half `memRdata[DATA_W-1:0]` becomes the word at offset 0 and the high half becomes the word at offset 1. `memReq` falls the next cycle, and the held request then hits.
- R6: Empty main slots are used before any valid line is displaced, so the first `MAIN_LINES` distinct lines fetched all stay resident.
- R7: When the main array is full, the slot displaced by a fill or a buffer swap is the one least recently accessed.
- R8: A valid line displaced from the main array by a fill enters the victim buffer, and a later access to it completes without `stall` and without `memReq`.
- R9: A buffer hit moves that line into the main array as most recently used. The main array's least recently used line takes the hit entry's place in the buffer, keeping that entry's position in the buffer's insertion order.
- R10: With the buffer full, a new displaced line overwrites the oldest inserted entry, and the dropped line misses on its next access.
- R11: Written data moves with a line through the buffer and back. A write to a line later dropped from the buffer is lost, so a refetch returns memory content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU access request present |
| reqWrite | input | 1 | Access is a write |
| reqAddr | input | ADDR_W | Word address; bit 0 picks the word inside the line |
| reqWdata | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid when the access completes |
| stall | output | 1 | Access cannot complete this cycle |
| memReq | output | 1 | Line fetch request to memory |
| memAddr | output | ADDR_W-1 | Line address being fetched |
| memValid | input | 1 | Burst data present on memRdata |
| memRdata | input | 2*DATA_W | Both words of the fetched line, offset 1 in the high half |

## Verification
The hardest situation to reach is a buffer swap or buffer drop whose result depends on the exact recency order of a full main array combined with the insertion order of a full buffer. These states only arise after long mixed histories. The stimulus first fills the array with distinct lines and then runs a long pseudo-random sweep over fourteen lines, more than the twelve the array and buffer can hold, with a queue-based reference model in the bench. This drives many swaps, drops and refetches, with writes mixed in so that lost and preserved data are both exercised.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef struct packed {
    logic touchHit;
    logic swap;
    logic fill;
    logic wrEn;
  } cacheStb_t;

  typedef enum logic {
    CTRL_IDLE,
    CTRL_WAIT
  } ctrlState_e;
endpackage

// File: rtl/fa_lru_matrix.sv
module fa_lru_matrix #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 touchEn,
  input  logic [$clog2(N)-1:0] touchIdx,
  output logic [$clog2(N)-1:0] lruIdx
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0] mat [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) mat[i] <= '0;
    end else if (touchEn) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touchIdx) mat[i] <= ~(N'(1) << touchIdx);
        else mat[i][touchIdx] <= 1'b0;
      end
    end
  end

  // Row of all zeros marks the oldest slot; lowest index wins ties
  always_comb begin
    lruIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mat[i] == '0) lruIdx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_cache_datapath.sv
module fa_cache_datapath
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int MAIN_LINES = 8,
  parameter int VICT_LINES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cacheStb_t             stb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [ADDR_W-2:0]     fillTag,
  input  logic [2*DATA_W-1:0]   memRdata,
  output logic [DATA_W-1:0]     rdData,
  output logic                  mainHit,
  output logic                  victHit,
  output logic [MAIN_LINES-1:0] mainHitVec,
  output logic [VICT_LINES-1:0] victHitVec
);
  localparam int TAG_W  = ADDR_W - 1;
  localparam int MIDX_W = $clog2(MAIN_LINES);
  localparam int VIDX_W = $clog2(VICT_LINES);

  typedef logic [1:0][DATA_W-1:0] line_t;

  logic [TAG_W-1:0]      mTag  [MAIN_LINES];
  line_t                 mData [MAIN_LINES];
  logic [MAIN_LINES-1:0] mValid, mDirty;
  logic [TAG_W-1:0]      vTag  [VICT_LINES];
  line_t                 vData [VICT_LINES];
  logic [VICT_LINES-1:0] vValid, vDirty;
  logic [VIDX_W-1:0]     vPtr;

  logic [TAG_W-1:0]  reqTag;
  logic              off;
  logic [MIDX_W-1:0] mainIdx, freeIdx, lruIdx, replIdx;
  logic [VIDX_W-1:0] victIdx;
  logic              freeFound;
  line_t             hitLine, newLine;

  assign reqTag = reqAddr[ADDR_W-1:1];
  assign off    = reqAddr[0];

  for (genvar g = 0; g < MAIN_LINES; g++) begin : gMainCmp
    assign mainHitVec[g] = mValid[g] && (mTag[g] == reqTag);
  end
  for (genvar g = 0; g < VICT_LINES; g++) begin : gVictCmp
    assign victHitVec[g] = vValid[g] && (vTag[g] == reqTag);
  end

  assign mainHit = |mainHitVec;
  assign victHit = |victHitVec;

  always_comb begin
    mainIdx   = '0;
    victIdx   = '0;
    freeIdx   = '0;
    freeFound = 1'b0;
    for (int i = MAIN_LINES - 1; i >= 0; i--) begin
      if (mainHitVec[i]) mainIdx = MIDX_W'(i);
      if (!mValid[i]) begin
        freeIdx   = MIDX_W'(i);
        freeFound = 1'b1;
      end
    end
    for (int j = VICT_LINES - 1; j >= 0; j--) begin
      if (victHitVec[j]) victIdx = VIDX_W'(j);
    end
  end

  assign replIdx = freeFound ? freeIdx : lruIdx;

  fa_lru_matrix #(.N(MAIN_LINES)) u_lru (
    .clk     (clk),
    .rstN    (rstN),
    .touchEn (stb.touchHit | stb.swap | stb.fill),
    .touchIdx(stb.touchHit ? mainIdx : replIdx),
    .lruIdx  (lruIdx)
  );

  always_comb begin
    hitLine = mainHit ? mData[mainIdx] : vData[victIdx];
    rdData  = hitLine[off];
    newLine = hitLine;
    if (stb.wrEn) newLine[off] = reqWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mValid <= '0;
      mDirty <= '0;
      vValid <= '0;
      vDirty <= '0;
      vPtr   <= '0;
    end else begin
      if (stb.touchHit && stb.wrEn) begin
        mData[mainIdx]  <= newLine;
        mDirty[mainIdx] <= 1'b1;
      end
      if (stb.swap) begin
        mTag[replIdx]   <= vTag[victIdx];
        mData[replIdx]  <= newLine;
        mValid[replIdx] <= 1'b1;
        mDirty[replIdx] <= vDirty[victIdx] | stb.wrEn;
        vTag[victIdx]   <= mTag[replIdx];
        vData[victIdx]  <= mData[replIdx];
        vValid[victIdx] <= mValid[replIdx];
        vDirty[victIdx] <= mDirty[replIdx];
      end
      if (stb.fill) begin
        mTag[replIdx]   <= fillTag;
        mData[replIdx]  <= memRdata;
        mValid[replIdx] <= 1'b1;
        mDirty[replIdx] <= 1'b0;
        if (mValid[replIdx]) begin
          vTag[vPtr]   <= mTag[replIdx];
          vData[vPtr]  <= mData[replIdx];
          vValid[vPtr] <= 1'b1;
          vDirty[vPtr] <= mDirty[replIdx];
          vPtr <= (vPtr == VIDX_W'(VICT_LINES - 1)) ? '0 : vPtr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fa_cache_ctrl.sv
module fa_cache_ctrl
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-2:0] reqTag,
  input  logic              mainHit,
  input  logic              victHit,
  input  logic              memValid,
  output cacheStb_t         stb,
  output logic              stall,
  output logic              memReq,
  output logic [ADDR_W-2:0] missTag
);
  ctrlState_e state;

  always_comb begin
    stb   = '0;
    stall = 1'b0;
    if (state == CTRL_IDLE) begin
      if (reqValid) begin
        if (mainHit)      stb.touchHit = 1'b1;
        else if (victHit) stb.swap     = 1'b1;
        else              stall        = 1'b1;
        stb.wrEn = reqWrite & (mainHit | victHit);
      end
    end else begin
      stall    = 1'b1;
      stb.fill = memValid;
    end
  end

  assign memReq = (state == CTRL_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= CTRL_IDLE;
      missTag <= '0;
    end else if (state == CTRL_IDLE) begin
      if (reqValid && !mainHit && !victHit) begin
        state   <= CTRL_WAIT;
        missTag <= reqTag;
      end
    end else if (memValid) begin
      state <= CTRL_IDLE;
    end
  end
endmodule

// File: rtl/fa_victim_cache.sv
module fa_victim_cache
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int MAIN_LINES = 8,
  parameter int VICT_LINES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic [DATA_W-1:0]   rdData,
  output logic                stall,
  output logic                memReq,
  output logic [ADDR_W-2:0]   memAddr,
  input  logic                memValid,
  input  logic [2*DATA_W-1:0] memRdata
);
  cacheStb_t             stb;
  logic                  mainHit, victHit;
  logic [MAIN_LINES-1:0] mainHitVec;
  logic [VICT_LINES-1:0] victHitVec;

  fa_cache_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqTag  (reqAddr[ADDR_W-1:1]),
    .mainHit (mainHit),
    .victHit (victHit),
    .memValid(memValid),
    .stb     (stb),
    .stall   (stall),
    .memReq  (memReq),
    .missTag (memAddr)
  );

  fa_cache_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAIN_LINES(MAIN_LINES),
    .VICT_LINES(VICT_LINES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .fillTag   (memAddr),
    .memRdata  (memRdata),
    .rdData    (rdData),
    .mainHit   (mainHit),
    .victHit   (victHit),
    .mainHitVec(mainHitVec),
    .victHitVec(victHitVec)
  );
endmodule

// File: rtl/fa_victim_cache_chk.sv
module fa_victim_cache_chk #(
  parameter int ADDR_W     = 16,
  parameter int MAIN_LINES = 8,
  parameter int VICT_LINES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  stall,
  input logic                  memReq,
  input logic                  memValid,
  input logic [ADDR_W-2:0]     memAddr,
  input logic [MAIN_LINES-1:0] mainHitVec,
  input logic [VICT_LINES-1:0] victHitVec
);
  assert_single_main_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mainHitVec));

  assert_main_hit_no_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !memReq && (|mainHitVec) |-> !stall);

  assert_miss_stalls_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !(|mainHitVec) && !(|victHitVec) |-> stall);

  assert_fetch_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  assert_fetch_stalls_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> stall);

  assert_fetch_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memValid |=> !memReq);

  assert_single_victim_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(victHitVec));

  assert_victim_hit_no_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !memReq && (|victHitVec) |-> !stall);

  assert_no_duplicate_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    !((|mainHitVec) && (|victHitVec)));
endmodule

bind fa_victim_cache fa_victim_cache_chk #(
  .ADDR_W    (ADDR_W),
  .MAIN_LINES(MAIN_LINES),
  .VICT_LINES(VICT_LINES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .stall     (stall),
  .memReq    (memReq),
  .memValid  (memValid),
  .memAddr   (memAddr),
  .mainHitVec(mainHitVec),
  .victHitVec(victHitVec)
);

// File: tb/fa_victim_cache_tb.sv
`timescale 1ns/1ps
module fa_victim_cache_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int MAIN_LINES = 8;
  localparam int VICT_LINES = 4;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic [DATA_W-1:0]   reqWdata = '0;
  logic [DATA_W-1:0]   rdData;
  logic                stall, memReq, memValid = 1'b0;
  logic [ADDR_W-2:0]   memAddr;
  logic [2*DATA_W-1:0] memRdata = '0;

  int checkCnt = 0, failCnt = 0;
  bit finished = 0;

  int mq[$];
  int vq[$];
  logic [DATA_W-1:0] shadow [int];

  always #2.5 clk = ~clk;

  fa_victim_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_LINES(MAIN_LINES),
    .VICT_LINES(VICT_LINES)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdData), .stall(stall),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memRdata(memRdata));

  function automatic logic [DATA_W-1:0] memWord(input int a);
    return (DATA_W'(a) * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: 0 main hit, 1 victim hit, 2 miss
  function automatic int modelAccess(input int t);
    int p;
    int ev;
    foreach (mq[i]) if (mq[i] == t) begin
      mq.delete(i);
      mq.push_back(t);
      return 0;
    end
    p = -1;
    foreach (vq[i]) if (vq[i] == t) p = i;
    if (p >= 0) begin
      ev = mq.pop_front();
      vq[p] = ev;
      mq.push_back(t);
      return 1;
    end
    if (mq.size() == MAIN_LINES) begin
      ev = mq.pop_front();
      if (vq.size() == VICT_LINES) begin
        int dropped;
        dropped = vq.pop_front();
        shadow.delete(2 * dropped);
        shadow.delete(2 * dropped + 1);
      end
      vq.push_back(ev);
    end
    mq.push_back(t);
    return 2;
  endfunction

  task automatic access(input bit wr, input int addr, input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd, output bit missed,
                        output bit sawMem, output bit addrOk);
    missed = 0; sawMem = 0; addrOk = 1;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(addr); reqWdata = wd;
    #1;
    while (stall) begin
      missed = 1;
      @(negedge clk);
      memValid = 1'b0;
      if (memReq) begin
        sawMem = 1;
        if (memAddr != (ADDR_W-1)'(addr >> 1)) addrOk = 0;
        memValid = 1'b1;
        memRdata = {memWord(2 * int'(memAddr) + 1), memWord(2 * int'(memAddr))};
      end
      #1;
    end
    rd = rdData;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    reqWrite = 1'b0;
  endtask

  task automatic step(input bit wr, input int addr, input logic [DATA_W-1:0] wd,
                      input string phase);
    int cls;
    logic [DATA_W-1:0] rd, exp;
    bit missed, sawMem, addrOk;
    cls = modelAccess(addr >> 1);
    exp = shadow.exists(addr) ? shadow[addr] : memWord(addr);
    access(wr, addr, wd, rd, missed, sawMem, addrOk);
    if (wr) shadow[addr] = wd;
    case (cls)
      0: check(!missed, {phase, " R2,R7 main hit without stall"}, DATA_W'(missed), 0);
      1: check(!missed && !sawMem, {phase, " R8,R9 victim hit without memory"},
               DATA_W'(sawMem), 0);
      default: begin
        check(missed && sawMem, {phase, " R4,R10 miss fetches line"}, DATA_W'(sawMem), 1);
        check(addrOk, {phase, " R4 memAddr is line address"}, DATA_W'(addrOk), 1);
      end
    endcase
    if (!wr) begin
      if (cls == 2) check(rd == exp, {phase, " R5,R11 fetched word order"}, rd, exp);
      else if (cls == 1) check(rd == exp, {phase, " R9,R11 swapped line data"}, rd, exp);
      else check(rd == exp, {phase, " R2,R3 hit data"}, rd, exp);
    end
  endtask

  initial begin
    logic [DATA_W-1:0] rd;
    bit missed, sawMem, addrOk;
    int seed;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!stall && !memReq, "R1 reset idle outputs", DATA_W'({stall, memReq}), 0);
    access(0, 6, 0, rd, missed, sawMem, addrOk);
    check(missed && sawMem, "R1 first access misses", DATA_W'(missed), 1);
    check(rd == memWord(6), "R5 low word from burst", rd, memWord(6));
    void'(modelAccess(3));
    // R6: fill remaining slots, then all original lines must still hit
    for (int t = 0; t < MAIN_LINES; t++) if (t != 3) step(0, 2 * t + 1, 0, "fill R6");
    for (int t = 0; t < MAIN_LINES; t++) step(0, 2 * t, 0, "resident R6");
    // R3: write one word, other word untouched
    step(1, 9, 32'hCAFE0009, "write R3");
    step(0, 9, 0, "readback R3");
    step(0, 8, 0, "neighbour R3");
    // R7: touch order leaves line 2 least recent, then evict it
    for (int t = 0; t < MAIN_LINES; t++) if (t != 2) step(0, 2 * t, 0, "touch R7");
    step(0, 2 * 20, 0, "evict R7");
    step(0, 2 * 2 + 1, 0, "victim R8");
    // Long mixed sweep over fourteen lines
    seed = 32'h1234567;
    for (int n = 0; n < 600; n++) begin
      int tg, of;
      bit wr;
      seed = seed * 1103515245 + 12345;
      tg = (seed >>> 16) & 32'h7FFF;
      tg = tg % 14;
      of = (seed >>> 9) & 1;
      wr = ((seed >>> 11) & 3) == 0;
      step(wr, 2 * tg + of, DATA_W'(seed) ^ 32'h5500AA00, "sweep R10,R11");
    end
    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule